// File: doc/BRIEF.md
# Three-Wire Control Word Transmitter

This block turns a parallel 8-bit control word into the serial form that a digitally controlled equalizer expects on its three control lines: a gated serial clock, a data line and a latch strobe. A single-cycle request while idle captures the word and shifts it out least significant bit first. The data line changes only while the serial clock is low, so every bit is stable across the rising clock edge on which the receiver samples it. After the eighth bit the serial clock stays off for a guard interval. The strobe then rises for a fixed width, and the serial clock and data are held low while it is high.

A pair mode sends two words in one request, each with its own strobe: first the band-select word, then the gain word. It covers the normal update order. A gain change to the band already selected can use the single-word mode with only the gain word. A busy output covers the whole sequence, and any request made while busy is dropped.

All timing comes from the system clock. `HALF_DIV` sets the half period of the serial clock and `GAP_DIV` sets the strobe width and the guard intervals. Each is raised to at least `CLK_MHZ` system cycles, which is one microsecond. That minimum gives at least 1 us of setup, hold, strobe width and strobe delay, and keeps the serial clock at or below 500 kHz.

Top module: `ctlword_tx`

## Requirements
- R1: While `busy` is low, a high `start` sampled on a rising `clk` edge captures `first_word`, `second_word` and `pair_mode`, and `busy` is high from the next cycle on.
- R2: Each word gives exactly eight rising edges of `ser_clk`. The value of `ser_data` at the k-th rising edge is bit k-1 of the word (bit 0 first).
- R3: `ser_data` never changes while `ser_clk` is high, and it never changes on the cycle in which `ser_clk` rises.
- R4: Let HALF = max(`HALF_DIV`, `CLK_MHZ`). Every high phase of `ser_clk` lasts HALF system cycles. Between two bits of one word the low phase also lasts HALF cycles, and the first bit of a request rises HALF cycles after `busy` rises.
- R5: Let GAP = max(`GAP_DIV`, `CLK_MHZ`). The strobe rises GAP cycles after the last falling edge of `ser_clk` in a word, and it stays high for GAP cycles.
- R6: While `latch_stb` is high, `ser_clk` and `ser_data` are both low.
- R7: With `pair_mode` = 1, `first_word` is sent and strobed, then `second_word` is sent and strobed. The first rising edge of `ser_clk` for the second word comes GAP + HALF cycles after the first strobe falls.
- R8: `busy` stays high until the last strobe of the request falls, and it drops on that same cycle. A `start` while `busy` is high is ignored and produces no extra word or strobe.
- R9: After reset, `ser_clk`, `ser_data`, `latch_stb` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request, sampled while idle |
| pair_mode | input | 1 | 1: send the band word then the gain word; 0: send `first_word` only |
| first_word | input | 8 | Word sent first (the band word in pair mode) |
| second_word | input | 8 | Gain word sent second in pair mode |
| ser_clk | output | 1 | Gated serial clock, idles low |
| ser_data | output | 1 | Serial data, LSB first, idles low |
| latch_stb | output | 1 | Latch strobe, idles low |
| busy | output | 1 | High from the cycle after an accepted request until its last strobe ends |

## Verification
Single words are sent with alternating bits (0xA5), with only the lowest bit set (0x01) and with only the highest bit set (0x80). These patterns separate a reversed bit order from an off-by-one shift or a dropped final bit. Pair requests with 0x3C/0xC3 and 0xFF/0x00 show whether the two words are swapped, merged or stuck, and whether the inter-word gap is correct. A second request made in the middle of a transfer, with different data, shows whether a request during busy is really dropped. A bench divider below `CLK_MHZ` shows the one-microsecond minimum being applied.

// File: rtl/ctlword_tx.sv
module ctlword_tx #(
  parameter int CLK_MHZ  = 4,
  parameter int HALF_DIV = 4,
  parameter int GAP_DIV  = 4,
  parameter int WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pair_mode,
  input  logic [WORD_W-1:0] first_word,
  input  logic [WORD_W-1:0] second_word,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              latch_stb,
  output logic              busy
);

  localparam int HALF = (HALF_DIV < CLK_MHZ) ? CLK_MHZ : HALF_DIV;
  localparam int GAP  = (GAP_DIV < CLK_MHZ) ? CLK_MHZ : GAP_DIV;
  localparam int MAXC = (HALF > GAP) ? HALF : GAP;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_PRE, S_STB, S_POST} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [WORD_W-1:0] sh, nxt;
  logic             pend;

  wire tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      nxt  <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            st   <= S_LO;
            cnt  <= CW'(HALF - 1);
            bidx <= '0;
            sh   <= first_word;
            nxt  <= second_word;
            pend <= pair_mode;
          end
        S_LO:
          if (tick) begin
            st  <= S_HI;
            cnt <= CW'(HALF - 1);
          end else cnt <= cnt - 1'b1;
        S_HI:
          if (tick) begin
            if (bidx == BW'(WORD_W - 1)) begin
              st  <= S_PRE;
              cnt <= CW'(GAP - 1);
            end else begin
              st   <= S_LO;
              cnt  <= CW'(HALF - 1);
              bidx <= bidx + 1'b1;
              sh   <= sh >> 1;
            end
          end else cnt <= cnt - 1'b1;
        S_PRE:
          if (tick) begin
            st  <= S_STB;
            cnt <= CW'(GAP - 1);
          end else cnt <= cnt - 1'b1;
        S_STB:
          if (tick) begin
            st  <= pend ? S_POST : S_IDLE;
            cnt <= CW'(GAP - 1);
          end else cnt <= cnt - 1'b1;
        S_POST:
          if (tick) begin
            st   <= S_LO;
            cnt  <= CW'(HALF - 1);
            bidx <= '0;
            sh   <= nxt;
            pend <= 1'b0;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ser_clk   = (st == S_HI);
  assign ser_data  = ((st == S_LO) || (st == S_HI)) && sh[0];
  assign latch_stb = (st == S_STB);
  assign busy      = (st != S_IDLE);

  // R3
  data_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R3
  data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R6
  quiet_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> (!ser_clk && !ser_data));

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5
  strobe_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_stb) |-> !$past(ser_clk));

  // R8
  busy_ends_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(latch_stb));

endmodule

// File: tb/ctlword_tx_bench.sv
module ctlword_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ  = 3;
  localparam int HDIV = 2;
  localparam int GDIV = 5;
  localparam int HALF = 3;
  localparam int GAP  = 5;

  logic clk = 0, rst_n = 0, start = 0, pair_mode = 0;
  logic [7:0] first_word = 0, second_word = 0;
  logic ser_clk, ser_data, latch_stb, busy;

  ctlword_tx #(.CLK_MHZ(MHZ), .HALF_DIV(HDIV), .GAP_DIV(GDIV), .WORD_W(8)) u_ctlword_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_mode(pair_mode),
    .first_word(first_word), .second_word(second_word),
    .ser_clk(ser_clk), .ser_data(ser_data), .latch_stb(latch_stb), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic [7:0] w; logic more; } exp_t;
  exp_t q[$];

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor
  logic pclk = 0, pstb = 0, pdata = 0, hdata = 0, second_first = 0;
  int lowrun = 0, highrun = 0, stbrun = 0, bits = 0;
  logic [7:0] cap = 0;
  int strobes = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !pclk) begin
        chk(lowrun == (second_first ? GAP + HALF : HALF), "R4/R7 low run before rise", lowrun,
            second_first ? GAP + HALF : HALF);
        chk(ser_data == pdata, "R3 data steady into rise", ser_data, pdata);
        cap = {ser_data, cap[7:1]};
        bits++;
        highrun = 1;
        hdata = ser_data;
        lowrun = 0;
        second_first = 0;
      end else if (ser_clk) begin
        highrun++;
        chk(ser_data == hdata, "R3 data steady while high", ser_data, hdata);
      end
      if (!ser_clk && pclk)
        chk(highrun == HALF, "R4 high phase length", highrun, HALF);
      if (latch_stb && !pstb) begin
        exp_t e;
        strobes++;
        chk(lowrun == GAP, "R5 guard before strobe", lowrun, GAP);
        chk(bits == 8, "R2 eight bits per word", bits, 8);
        if (q.size() == 0) begin
          chk(0, "R8 unexpected strobe", cap, -1);
          e = '0;
        end else begin
          e = q.pop_front();
          chk(cap == e.w, "R2 word value LSB first", cap, e.w);
        end
        second_first = e.more;
        stbrun = 1;
      end else if (latch_stb) begin
        stbrun++;
      end
      if (latch_stb)
        chk(!ser_clk && !ser_data, "R6 quiet during strobe", {ser_clk, ser_data}, 0);
      if (!latch_stb && pstb) begin
        chk(stbrun == GAP, "R5 strobe width", stbrun, GAP);
        chk(busy == second_first, "R8/R7 busy at strobe end", busy, second_first);
        lowrun = 0;
        bits = 0;
      end
      if (busy && !ser_clk && !latch_stb) lowrun++;
      if (!busy) begin lowrun = 0; bits = 0; end
      pclk = ser_clk; pstb = latch_stb; pdata = ser_data;
    end
  end

  task automatic send(input logic [7:0] a, input logic [7:0] b, input bit pair);
    exp_t e;
    e.w = a; e.more = pair; q.push_back(e);
    if (pair) begin e.w = b; e.more = 0; q.push_back(e); end
    @(negedge clk);
    first_word = a; second_word = b; pair_mode = pair; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    while (busy) @(negedge clk);
    chk(!ser_clk && !ser_data && !latch_stb, "R9 idle after request",
        {ser_clk, ser_data, latch_stb}, 0);
  endtask

  task automatic send_with_intrusion(input logic [7:0] a);
    exp_t e;
    e.w = a; e.more = 0; q.push_back(e);
    @(negedge clk);
    first_word = a; pair_mode = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    first_word = ~a; second_word = 8'h5A; pair_mode = 1; start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    repeat (GAP + 4 * HALF) @(negedge clk);
    chk(busy == 0, "R8 start during busy ignored", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({ser_clk, ser_data, latch_stb, busy} == 0, "R9 reset state",
        {ser_clk, ser_data, latch_stb, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    send(8'hA5, 8'h00, 0);
    send(8'h01, 8'h00, 0);
    send(8'h80, 8'h00, 0);
    send(8'h3C, 8'hC3, 1);
    send_with_intrusion(8'h96);
    send(8'hFF, 8'h00, 1);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2/R7 all expected words strobed", q.size(), 0);
    chk(strobes == 8, "R8 strobe count", strobes, 8);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule